// File: doc/BRIEF.md
# Switching Period Guard

This block sits on the secondary side of a flyback converter, next to the synchronous-rectifier (SR) gate logic. It receives a one-cycle strobe for each rising edge of the synchronised winding-detect signal. It counts clock cycles between consecutive strobes to measure the primary switching period, using a saturating cycle counter. From that measurement and from the measured length of each SR gate pulse it builds three protections. The first is a per-period cutoff that forces the gate off shortly before the next primary turn-on can be expected. The second is a fault strobe when the period suddenly stretches. The third is a cap on how much the SR on-time may grow from one pulse to the next, so that the gate cannot overlap the primary switch during a fast load step.

The block's single request output, `off_req`, is the OR of the predicted turn-off request coming from the timing predictor and the block's own limits. The gate driver turns the SR switch off whenever `off_req` is high. `fault_stb` goes to the sleep controller. Percentages use integer multiply-then-shift arithmetic that rounds toward the shorter time. The defaults are 993/1024 for the cutoff, 1177/1024 for the on-time cap, and "5·P > 6·P_prev" for the fault test.

A state machine has four states: `ST_IDLE` (no edge yet), `ST_LEARN` (one edge seen, no reference period), `ST_TRACK` (reference period valid, limits armed) and `ST_BLOCK` (after a fault, gate held off). Its transitions on an edge strobe are as follows:
- `ST_IDLE→ST_LEARN` on the first edge.
- `ST_LEARN→ST_TRACK` on an unsaturated period; `ST_LEARN→ST_LEARN` on a saturated period.
- `ST_TRACK→ST_BLOCK` on a stretched or saturated period; `ST_TRACK→ST_TRACK` otherwise.
- `ST_BLOCK→ST_TRACK` on an unsaturated period; `ST_BLOCK→ST_LEARN` on a saturated period.

Top module: `per_guard`

## Requirements
- R1: From reset until a reference period exists (states `ST_IDLE` and `ST_LEARN`), no period cutoff is applied and `fault_stb` stays low.
- R2: The period P is the number of clock cycles from one `edge_stb` cycle to the next. In `ST_TRACK`, `off_req` is high from floor(P·993/1024) cycles after an edge until the next edge, using the most recent accepted P. The edge cycle itself carries no cutoff.
- R3: In `ST_TRACK`, a measured P with 5·P > 6·P_prev raises `fault_stb` in the cycle after that edge. P equal to exactly 1.2·P_prev raises no fault.
- R4: After a fault, `off_req` stays high until the next edge. The period measured at that edge becomes the new reference without a fault test.
- R5: The period counter saturates at 2^CNT_W−1 (4095 by default) and never wraps. A saturated measurement in `ST_TRACK` is a fault.
- R6: Once a previous SR pulse of N cycles has been recorded, `off_req` goes high when the current pulse has been high for floor(N·1177/1024) cycles.
- R7: No on-time cap applies before the first recorded pulse after reset, nor after a fault until a new pulse is recorded.
- R8: `pred_off` high always drives `off_req` high in the same cycle.
- R9: `fault_stb` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_stb | input | 1 | One-cycle strobe on a winding-detect rising edge |
| gate_on | input | 1 | Current SR gate state (1 = on) |
| pred_off | input | 1 | Turn-off request from the timing predictor |
| off_req | output | 1 | Combined SR turn-off request |
| fault_stb | output | 1 | One-cycle period fault pulse toward the sleep controller |

## Verification
The directed corner cases are the following. A period of exactly 120% must not fault, while one cycle more beyond that ratio must fault; a comparison of the wrong strictness flips one of these. A pulse well beyond 115% of the previous pulse must be cut at the rounded-down cycle; off-by-one rounding moves the cut by a cycle. A gap longer than the counter range must fault rather than wrap into a short, harmless-looking period. The pulse after a fault must run uncapped and the period after a fault must not be tested, otherwise a stale history would cut or fault it. Constrained-random periods and pulses then compare `off_req` and `fault_stb` every cycle against a bench model built from the requirements.

// File: rtl/per_guard_pkg.sv
package per_guard_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEARN = 2'd1,
        ST_TRACK = 2'd2,
        ST_BLOCK = 2'd3
    } pg_state_e;
endpackage

// File: rtl/per_guard_satcnt.sv
module per_guard_satcnt #(
    parameter int W       = 12,
    parameter int CLR_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         sat
);
    assign sat = &cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= W'(CLR_VAL);
        else if (inc && !sat) cnt <= cnt + 1'b1;
    end

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> sat);
endmodule

// File: rtl/per_guard_scale.sv
module per_guard_scale #(
    parameter int W   = 12,
    parameter int NUM = 993,
    parameter int SH  = 10
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] res
);
    localparam int NW = $clog2(NUM + 1);
    localparam int PW = W + NW;

    logic [PW-1:0] prod;
    logic [PW-1:0] quo;

    assign prod = PW'(val) * PW'(NUM);
    assign quo  = prod >> SH;
    assign res  = (|quo[PW-1:W]) ? '1 : quo[W-1:0];
endmodule

// File: rtl/per_guard.sv
module per_guard
    import per_guard_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int CUT_NUM  = 993,
    parameter int CUT_SH   = 10,
    parameter int GROW_NUM = 1177,
    parameter int GROW_SH  = 10,
    parameter int FLT_NUM  = 6,
    parameter int FLT_DEN  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_stb,
    input  logic gate_on,
    input  logic pred_off,
    output logic off_req,
    output logic fault_stb
);
    localparam int CW = CNT_W + 4;

    pg_state_e st, st_nx;

    logic [CNT_W-1:0] per_cnt, on_cnt, cut_val, grow_val;
    logic [CNT_W-1:0] prev_per, cut_lim, grow_lim;
    logic             per_sat, on_sat, gate_d, on_ok;
    logic             fall, slow, fault_now, load_per;
    logic             per_cut, grow_cut;
    logic [CW-1:0]    slow_lhs, slow_rhs;

    per_guard_satcnt #(.W(CNT_W), .CLR_VAL(1)) u_per_cnt (
        .clk(clk), .rst_n(rst_n), .clr(edge_stb), .inc(1'b1),
        .cnt(per_cnt), .sat(per_sat));

    per_guard_satcnt #(.W(CNT_W), .CLR_VAL(0)) u_on_cnt (
        .clk(clk), .rst_n(rst_n), .clr(edge_stb), .inc(gate_on),
        .cnt(on_cnt), .sat(on_sat));

    per_guard_scale #(.W(CNT_W), .NUM(CUT_NUM), .SH(CUT_SH)) u_cut (
        .val(per_cnt), .res(cut_val));

    per_guard_scale #(.W(CNT_W), .NUM(GROW_NUM), .SH(GROW_SH)) u_grow (
        .val(on_cnt), .res(grow_val));

    assign fall     = gate_d && !gate_on;
    assign slow_lhs = CW'(per_cnt) * CW'(FLT_DEN);
    assign slow_rhs = CW'(prev_per) * CW'(FLT_NUM);
    assign slow     = per_sat || (slow_lhs > slow_rhs);
    assign fault_now = edge_stb && (st == ST_TRACK) && slow;

    // next state
    always_comb begin
        st_nx    = st;
        load_per = 1'b0;
        unique case (st)
            ST_IDLE:  if (edge_stb) st_nx = ST_LEARN;
            ST_LEARN: if (edge_stb && !per_sat) begin
                          st_nx    = ST_TRACK;
                          load_per = 1'b1;
                      end
            ST_TRACK: if (edge_stb) begin
                          if (slow) st_nx = ST_BLOCK;
                          else      load_per = 1'b1;
                      end
            ST_BLOCK: if (edge_stb) begin
                          if (per_sat) st_nx = ST_LEARN;
                          else begin
                              st_nx    = ST_TRACK;
                              load_per = 1'b1;
                          end
                      end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_per  <= '0;
            cut_lim   <= '0;
            grow_lim  <= '0;
            on_ok     <= 1'b0;
            gate_d    <= 1'b0;
            fault_stb <= 1'b0;
        end else begin
            gate_d    <= gate_on;
            fault_stb <= fault_now;
            if (load_per) begin
                prev_per <= per_cnt;
                cut_lim  <= cut_val;
            end
            if (fault_now) begin
                on_ok <= 1'b0;
            end else if (fall && (st == ST_LEARN || st == ST_TRACK)) begin
                grow_lim <= grow_val;
                on_ok    <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        per_cut  = (st == ST_TRACK) && !edge_stb && (per_cnt >= cut_lim);
        grow_cut = on_ok && gate_on && (on_cnt >= grow_lim);
        off_req  = pred_off || (st == ST_BLOCK) || per_cut || grow_cut;
    end

    // R9
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb |=> !fault_stb);
    // R3
    fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb |-> ($past(edge_stb) && $past(st == ST_TRACK)));
    // R4
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK) |-> off_req);
    // R8
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_off |-> off_req);
    // R1
    learn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_LEARN) |-> !fault_stb);
    // R2
    cut_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cut_val <= per_cnt);
endmodule

// File: tb/per_guard_test.sv
module per_guard_test;
    localparam int MAXC = 4095;

    logic clk = 1'b0;
    logic rst_n, edge_stb, gate_on, pred_off;
    logic off_req, fault_stb;

    int checks = 0;
    int fails  = 0;

    // bench model of the requirements
    int  ms = 0;        // 0 idle, 1 learn, 2 track, 3 block
    int  el = 0;        // cycles since last edge (unbounded)
    int  mprev = 0, mlim = 0, mon = 0, mlimon = 0;
    bit  monok = 0, mgd = 0, mfault = 0;
    string ftag = "R1";

    always #10 clk = ~clk;

    per_guard uut (
        .clk(clk), .rst_n(rst_n), .edge_stb(edge_stb), .gate_on(gate_on),
        .pred_off(pred_off), .off_req(off_req), .fault_stb(fault_stb));

    function automatic int cut_f(int p);
        return (p * 993) >> 10;
    endfunction
    function automatic int grow_f(int n);
        int r = (n * 1177) >> 10;
        return (r > MAXC) ? MAXC : r;
    endfunction
    function automatic bit slow_f(int p, int prev);
        return (p == MAXC) || (5 * p > 6 * prev);
    endfunction

    task automatic check(string tag, bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(bit e, bit g, bit p);
        bit pc, gc, oexp, fall;
        int pm;
        string t;
        @(negedge clk);
        edge_stb = e; gate_on = g; pred_off = p;
        #5;
        pm   = (el > MAXC) ? MAXC : el;
        pc   = (ms == 2) && !e && (pm >= mlim);
        gc   = monok && g && (mon >= mlimon);
        oexp = p || (ms == 3) || pc || gc;
        if (ms == 0 || ms == 1) t = "R1";
        else if (ms == 3)       t = "R4";
        else if (gc)            t = "R6";
        else if (pc)            t = "R2";
        else if (g && !monok)   t = "R7";
        else if (p)             t = "R8";
        else                    t = "R2";
        check(t, off_req, oexp, "off_req");
        check(ftag, fault_stb, mfault, "fault_stb");
        @(posedge clk);
        // model update
        fall = mgd && !g;
        if (fall && (ms == 1 || ms == 2)) begin
            monok = 1; mlimon = grow_f(mon);
        end
        ftag = mfault ? "R9" : "R3";
        mfault = 0;
        if (e) begin
            case (ms)
                0: ms = 1;
                1: if (pm != MAXC) begin ms = 2; mprev = pm; mlim = cut_f(pm); end
                2: if (slow_f(pm, mprev)) begin
                       ms = 3; mfault = 1; monok = 0;
                       ftag = (pm == MAXC) ? "R5" : "R3";
                   end else begin mprev = pm; mlim = cut_f(pm); end
                default: if (pm == MAXC) ms = 1;
                         else begin ms = 2; mprev = pm; mlim = cut_f(pm); end
            endcase
        end
        if (e) mon = 0;
        else if (g && mon < MAXC) mon++;
        if (e) el = 1; else el++;
        mgd = g;
    endtask

    task automatic run_period(int per, int gs, int gl, int pp, bit rnd);
        for (int k = 0; k < per; k++) begin
            bit p = (k == pp) || (rnd && ($urandom_range(0, 31) == 0));
            cyc(k == 0, (k >= gs) && (k < gs + gl), p);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; edge_stb = 0; gate_on = 0; pred_off = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state, R8 pass-through while idle
        repeat (5) cyc(0, 0, 0);
        cyc(0, 0, 1);
        cyc(0, 0, 0);
        // learn then track, R2 cutoff at 96 of 100
        run_period(100, 5, 50, -1, 0);
        run_period(100, 5, 50, 70, 0);
        run_period(100, 5, 50, -1, 0);
        // R6 on-time cap: 40 then 80 -> cut at 45
        run_period(100, 5, 40, -1, 0);
        run_period(100, 5, 80, -1, 0);
        // R3 exact 120% no fault, then 145 after 120 faults
        run_period(120, 5, 40, -1, 0);
        run_period(145, 5, 40, -1, 0);
        // R4 blocked period; R7 uncapped pulse after fault
        run_period(100, 5, 40, -1, 0);
        run_period(100, 5, 90, -1, 0);
        run_period(100, 5, 40, -1, 0);
        // R5 saturation fault
        run_period(5000, 5, 40, -1, 0);
        run_period(100, 5, 40, -1, 0);
        run_period(100, 5, 40, -1, 0);
        // constrained random
        for (int i = 0; i < 250; i++) begin
            int per = $urandom_range(60, 140);
            int gs  = $urandom_range(2, 10);
            int gl  = $urandom_range(5, per - gs - 3);
            run_period(per, gs, gl, -1, 1);
        end
        cyc(1, 0, 0);
        cyc(0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule